// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block gathers every reason the chip may need to restart into a single synchronous system reset. Seven request classes feed it: the supply monitor (power-on or power-fail), the bidirectional external reset pin, an external convert-start input, a software reset command, a comparator output, a missing-clock event and a watchdog expiry. Three of these classes can be switched off one at a time with their own enable inputs. Supply-class resets are stretched by a timeout counter. Only these resets pull the external pin low, through an open-drain enable. The pin's read-back value is itself one of the reset requests.

A cause register keeps one bit per source. Each reset event sets exactly one bit, for the winning source. The bits accumulate across later resets until a power-class reset clears them. While reset is held, the port output latch reads all ones and the watchdog is enabled with its longest interval selected. A one-cycle start pulse tells the core to begin fetching at address 0x0000. The inputs that come from outside the chip pass through two-flop synchronisers.

Top module: `sysreset_hub`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is low and `cause` equals 7'b0000001. Once `rst_n` has been released, `sys_rst_n` stays low until the supply timeout and the pin read-back have both cleared.
- R2: A supply-class request asserts reset. This is `supply_fail`, or `sw_por` when software writes the power flag, held for H cycles. When the pin loops back, `sys_rst_n` is low for H+TIMEOUT_CYC+2 cycles, and `cause` becomes exactly 7'b0000001.
- R3: `pin_oe` is high only for supply-class resets. It stays high for H+TIMEOUT_CYC-1 cycles, and `pin_oe` high always implies `sys_rst_n` low.
- R4: `sw_reset` and `wdt_expire` held for H cycles make `sys_rst_n` low for H cycles, starting at the next clock edge.
- R5: A low level on `pin_in`, or a high level on `cnv_in` or `cmp_in` while enabled, held for H cycles makes `sys_rst_n` low for H cycles. These inputs pass through two synchroniser flops first.
- R6: With `en_cnv`, `en_cmp` or `en_mcd` low, the matching source has no effect on `sys_rst_n` or `cause`.
- R7: The missing-clock source reacts only to a rising edge of `mcd_event`. It gives a one-cycle reset however long the input stays high.
- R8: Cause bit positions are: 0 supply/power, 1 pin, 2 convert-start, 3 software, 4 comparator, 5 missing clock, 6 watchdog. Each event sets only the lowest-numbered active source, and bits stay set until a power-class reset.
- R9: A non-power request that arrives while reset is already held adds no cause bit.
- R10: `port_latch` reads all ones in every cycle in which `sys_rst_n` is low. Otherwise `port_we` loads `port_d` into it.
- R11: While `sys_rst_n` is low, `wdt_en` is 1 and `wdt_sel` is all ones. After reset, `wdt_disable` clears `wdt_en`, and `wdt_sel_we` loads `wdt_sel_d`.
- R12: `core_start` is high for exactly one cycle per reset: the first cycle in which `sys_rst_n` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| supply_fail | input | 1 | Supply monitor request |
| sw_por | input | 1 | Software write of the power flag |
| sw_reset | input | 1 | Software reset command |
| wdt_expire | input | 1 | Watchdog timeout request |
| mcd_event | input | 1 | Missing-clock detector output |
| pin_in | input | 1 | External reset pin read-back, active low, asynchronous |
| cnv_in | input | 1 | Convert-start input, active high, asynchronous |
| cmp_in | input | 1 | Comparator output, active high, asynchronous |
| en_cnv | input | 1 | Enable for the convert-start source |
| en_cmp | input | 1 | Enable for the comparator source |
| en_mcd | input | 1 | Enable for the missing-clock source |
| port_we | input | 1 | Port latch write strobe |
| port_d | input | PORT_W | Port latch write data |
| wdt_disable | input | 1 | Watchdog disable command |
| wdt_sel_we | input | 1 | Watchdog interval write strobe |
| wdt_sel_d | input | WDT_SEL_W | Watchdog interval write data |
| sys_rst_n | output | 1 | System reset, active low |
| pin_oe | output | 1 | Open-drain enable that pulls the reset pin low |
| core_start | output | 1 | One-cycle pulse: core starts at address 0x0000 |
| cause | output | 7 | Sticky reset cause bits |
| port_latch | output | PORT_W | Port output latch |
| wdt_en | output | 1 | Watchdog enable |
| wdt_sel | output | WDT_SEL_W | Watchdog interval select |

## Verification
The pin loop-back is the hardest case. A design that lets its own pin drive register as a new cause would add bit 1 on every supply reset. A design that ignores the read-back would end the reset two cycles early. The bench fires several sources in the same cycle, which would expose a priority encoder that picks the wrong bit or sets several bits. It holds the missing-clock input high for many cycles to catch a level-sensitive detector, and it fires a watchdog expiry inside a supply reset to catch flags that are recorded on an ongoing reset. Random runs change the enables and the hold lengths, so a gating fault or a miscounted timeout shows up as a wrong reset length.

// File: rtl/rstc_pkg.sv
// Shared source numbering for the reset controller.
// Assumes: the bit order is also the cause priority (lower index wins).
package rstc_pkg;
    localparam int NSRC    = 7;
    localparam int SRC_PWR = 0;
    localparam int SRC_PIN = 1;
    localparam int SRC_CNV = 2;
    localparam int SRC_SW  = 3;
    localparam int SRC_CMP = 4;
    localparam int SRC_MCD = 5;
    localparam int SRC_WDT = 6;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/rstc_sync.sv
// Two-flop synchroniser bank for asynchronous inputs.
// Assumes: each bit is independent; RST_VAL gives the idle level per bit.
module rstc_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/rstc_timeout.sv
// Supply reset timeout: reloads on every load request, counts down to zero.
// Assumes: power-on reset also loads the full count.
module rstc_timeout #(
    parameter int TIMEOUT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] TOP = CW'(TIMEOUT);

    logic [CW-1:0] cnt;

    // Reload on request, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= TOP;
        else if (load)       cnt <= TOP;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/rstc_cause.sv
// Sticky reset cause register with priority selection.
// Assumes: req[0] is the power class; other bits are recorded only on entry.
module rstc_cause
    import rstc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t req,
    input  logic     in_reset,
    output src_vec_t cause
);
    src_vec_t pick;

    // Isolate the lowest-numbered active request.
    always_comb pick = req & (~req + src_vec_t'(1));

    // Power class clears and sets bit 0; other events add one bit on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= src_vec_t'(1);
        else if (req[SRC_PWR])
            cause <= src_vec_t'(1);
        else if (!in_reset && (req != '0))
            cause <= cause | pick;
    end
endmodule

// File: rtl/sysreset_hub.sv
// Multi-source system reset controller.
// Merges seven reset request classes, stretches supply resets, drives the
// open-drain reset pin, tracks causes and sets the post-reset state of the
// port latch and watchdog. Assumes one clock domain; pin, convert-start and
// comparator inputs are asynchronous and synchronised here.
module sysreset_hub
    import rstc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 200,
    parameter int PORT_W      = 8,
    parameter int WDT_SEL_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 supply_fail,
    input  logic                 sw_por,
    input  logic                 sw_reset,
    input  logic                 wdt_expire,
    input  logic                 mcd_event,
    input  logic                 pin_in,
    input  logic                 cnv_in,
    input  logic                 cmp_in,
    input  logic                 en_cnv,
    input  logic                 en_cmp,
    input  logic                 en_mcd,
    input  logic                 port_we,
    input  logic [PORT_W-1:0]    port_d,
    input  logic                 wdt_disable,
    input  logic                 wdt_sel_we,
    input  logic [WDT_SEL_W-1:0] wdt_sel_d,
    output logic                 sys_rst_n,
    output logic                 pin_oe,
    output logic                 core_start,
    output logic [NSRC-1:0]      cause,
    output logic [PORT_W-1:0]    port_latch,
    output logic                 wdt_en,
    output logic [WDT_SEL_W-1:0] wdt_sel
);
    localparam int NASYNC = 3;

    logic [NASYNC-1:0] async_raw, async_s;
    logic              mcd_q;
    logic              busy;
    logic              pwr_req;
    src_vec_t          req;
    logic              nxt_rst;
    logic              in_reset;

    assign async_raw = {cmp_in, cnv_in, pin_in};

    rstc_sync #(.W(NASYNC), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_raw),
        .q     (async_s)
    );

    // Edge memory for the one-shot missing-clock source.
    always_ff @(posedge clk) begin
        if (!rst_n) mcd_q <= 1'b0;
        else        mcd_q <= mcd_event;
    end

    assign pwr_req = supply_fail | sw_por;

    // Gate and collect all requests in priority order.
    always_comb begin
        req          = '0;
        req[SRC_PWR] = pwr_req;
        req[SRC_PIN] = ~async_s[0];
        req[SRC_CNV] = en_cnv & async_s[1];
        req[SRC_SW]  = sw_reset;
        req[SRC_CMP] = en_cmp & async_s[2];
        req[SRC_MCD] = en_mcd & mcd_event & ~mcd_q;
        req[SRC_WDT] = wdt_expire;
    end

    rstc_timeout #(.TIMEOUT(TIMEOUT_CYC)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pwr_req),
        .busy  (busy)
    );

    assign nxt_rst = (req != '0) | busy;

    // Reset state register and release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_reset   <= 1'b1;
            core_start <= 1'b0;
        end else begin
            in_reset   <= nxt_rst;
            core_start <= in_reset & ~nxt_rst;
        end
    end

    rstc_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .in_reset (in_reset),
        .cause    (cause)
    );

    // Port latch: all ones while reset is held, else written by the core.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt_rst) port_latch <= '1;
        else if (port_we)      port_latch <= port_d;
    end

    // Watchdog control: forced on at longest interval while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt_rst) begin
            wdt_en  <= 1'b1;
            wdt_sel <= '1;
        end else begin
            if (wdt_disable) wdt_en  <= 1'b0;
            if (wdt_sel_we)  wdt_sel <= wdt_sel_d;
        end
    end

    assign sys_rst_n = ~in_reset;
    assign pin_oe    = busy;
endmodule

// File: rtl/rstc_checker.sv
// Property checker for sysreset_hub, attached by bind.
// Assumes: rst_n is the power-on reset of the checked block.
module rstc_checker #(
    parameter int NSRC      = 7,
    parameter int PORT_W    = 8,
    parameter int WDT_SEL_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sys_rst_n,
    input logic                 pin_oe,
    input logic                 core_start,
    input logic [NSRC-1:0]      cause,
    input logic [PORT_W-1:0]    port_latch,
    input logic                 wdt_en,
    input logic [WDT_SEL_W-1:0] wdt_sel
);
    p_pin_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> !sys_rst_n);

    p_port_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> (port_latch == {PORT_W{1'b1}}));

    p_wdt_forced_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> (wdt_en && (wdt_sel == {WDT_SEL_W{1'b1}})));

    p_start_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (sys_rst_n && !$past(sys_rst_n)));

    p_one_new_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause & ~$past(cause)) <= 1);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(cause) & ~cause) == '0) || (cause == NSRC'(1))));
endmodule

bind sysreset_hub rstc_checker #(
    .NSRC(rstc_pkg::NSRC), .PORT_W(PORT_W), .WDT_SEL_W(WDT_SEL_W)
) u_rstc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst_n  (sys_rst_n),
    .pin_oe     (pin_oe),
    .core_start (core_start),
    .cause      (cause),
    .port_latch (port_latch),
    .wdt_en     (wdt_en),
    .wdt_sel    (wdt_sel)
);

// File: tb/test_sysreset_hub.sv
module test_sysreset_hub;
    localparam int T  = 40;
    localparam int PW = 8;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_fail = 0, sw_por = 0, sw_reset = 0, wdt_expire = 0, mcd_event = 0;
    logic ext_pin = 1, cnv_in = 0, cmp_in = 0;
    logic en_cnv = 0, en_cmp = 0, en_mcd = 0;
    logic port_we = 0, wdt_disable = 0, wdt_sel_we = 0;
    logic [PW-1:0] port_d = '0;
    logic [SW-1:0] wdt_sel_d = '0;
    logic sys_rst_n, pin_oe, core_start, wdt_en, pin_in;
    logic [6:0] cause;
    logic [PW-1:0] port_latch;
    logic [SW-1:0] wdt_sel;

    int checks = 0, failures = 0;
    logic [6:0] exp_cause = 7'd1;

    always #2 clk = ~clk;

    assign pin_in = pin_oe ? 1'b0 : ext_pin;

    sysreset_hub #(.TIMEOUT_CYC(T), .PORT_W(PW), .WDT_SEL_W(SW)) i_sysreset_hub (
        .clk(clk), .rst_n(rst_n), .supply_fail(supply_fail), .sw_por(sw_por),
        .sw_reset(sw_reset), .wdt_expire(wdt_expire), .mcd_event(mcd_event),
        .pin_in(pin_in), .cnv_in(cnv_in), .cmp_in(cmp_in), .en_cnv(en_cnv),
        .en_cmp(en_cmp), .en_mcd(en_mcd), .port_we(port_we), .port_d(port_d),
        .wdt_disable(wdt_disable), .wdt_sel_we(wdt_sel_we), .wdt_sel_d(wdt_sel_d),
        .sys_rst_n(sys_rst_n), .pin_oe(pin_oe), .core_start(core_start),
        .cause(cause), .port_latch(port_latch), .wdt_en(wdt_en), .wdt_sel(wdt_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit en_ok(input int src);
        case (src)
            2: return en_cnv;
            4: return en_cmp;
            5: return en_mcd;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int exp_low(input int src, input int hold, input bit ok);
        if (!ok) return 0;
        if (src == 0) return hold + T + 2;
        if (src == 5) return 1;
        return hold;
    endfunction

    function automatic int exp_oe(input int src, input int hold);
        return (src == 0) ? hold + T - 1 : 0;
    endfunction

    function automatic logic [6:0] next_cause(input logic [6:0] c, input int src, input bit ok);
        if (src == 0) return 7'd1;
        if (!ok) return c;
        return c | (7'd1 << src);
    endfunction

    task automatic drive(input int src, input bit alt, input logic v);
        case (src)
            0: if (alt) sw_por = v; else supply_fail = v;
            1: ext_pin = ~v;
            2: cnv_in = v;
            3: sw_reset = v;
            4: cmp_in = v;
            5: mcd_event = v;
            default: wdt_expire = v;
        endcase
    endtask

    // Hold one source for 'hold' cycles; count reset, pin and start cycles.
    // A watchdog pulse can be injected at cycle 'inj' (0 = none).
    task automatic run_case(input int src, input bit alt, input int hold, input int inj,
                            output int lows, output int oes, output int starts);
        lows = 0; oes = 0; starts = 0;
        @(negedge clk);
        drive(src, alt, 1'b1);
        for (int i = 1; i <= hold + T + 12; i++) begin
            @(negedge clk);
            if (!sys_rst_n) lows++;
            if (pin_oe) oes++;
            if (core_start) starts++;
            if (i == hold) drive(src, alt, 1'b0);
            if (inj != 0 && i == inj) wdt_expire = 1'b1;
            if (inj != 0 && i == inj + 1) wdt_expire = 1'b0;
        end
    endtask

    initial begin
        int lows, oes, starts, cnt, dummy;
        dummy = $urandom(32'h5eed);

        // Power-on reset state.
        repeat (3) @(negedge clk);
        check(sys_rst_n == 1'b0, "R1 reset held", sys_rst_n, 0);
        check(cause == 7'd1, "R1 cause at power-on", cause, 1);
        check(pin_oe == 1'b1, "R3 pin driven at power-on", pin_oe, 1);
        check(port_latch == 8'hFF, "R10 port ones in reset", port_latch, 255);
        check(wdt_en && wdt_sel == 2'b11, "R11 watchdog forced", {wdt_en, wdt_sel}, 7);
        rst_n = 1'b1;
        cnt = 0;
        while (!sys_rst_n && cnt < T + 20) begin @(negedge clk); cnt++; end
        check(sys_rst_n == 1'b1, "R1 reset released", sys_rst_n, 1);
        check(cnt >= T, "R1 timeout stretch", cnt, T);
        check(cause == 7'd1, "R1 cause after release", cause, 1);

        // Port latch write, then forced by reset.
        @(negedge clk); port_we = 1; port_d = 8'h5A;
        @(negedge clk); port_we = 0;
        check(port_latch == 8'h5A, "R10 port write", port_latch, 'h5A);
        // Watchdog changes after reset.
        wdt_disable = 1; wdt_sel_we = 1; wdt_sel_d = 2'b01;
        @(negedge clk); wdt_disable = 0; wdt_sel_we = 0;
        check(!wdt_en && wdt_sel == 2'b01, "R11 watchdog writable", {wdt_en, wdt_sel}, 1);
        sw_reset = 1;
        @(negedge clk); sw_reset = 0;
        check(!sys_rst_n && port_latch == 8'hFF, "R10 port forced", port_latch, 255);
        check(wdt_en && wdt_sel == 2'b11, "R11 watchdog restored", {wdt_en, wdt_sel}, 7);
        repeat (3) @(negedge clk);
        exp_cause = 7'b0001001;
        check(cause == exp_cause, "R8 software cause", cause, exp_cause);

        // Priority: software, missing clock and watchdog together.
        en_mcd = 1;
        @(negedge clk); sw_reset = 1; wdt_expire = 1; mcd_event = 1;
        @(negedge clk); sw_reset = 0; wdt_expire = 0; mcd_event = 0;
        repeat (4) @(negedge clk);
        check(cause == exp_cause, "R8 priority one bit", cause, exp_cause);

        // Missing clock held long: one cycle.
        run_case(5, 0, 6, 0, lows, oes, starts);
        check(lows == 1, "R7 one-shot length", lows, 1);
        exp_cause = exp_cause | 7'b0100000;
        check(cause == exp_cause, "R7 one-shot cause", cause, exp_cause);

        // Disabled comparator: no effect.
        en_cmp = 0;
        run_case(4, 0, 3, 0, lows, oes, starts);
        check(lows == 0 && cause == exp_cause, "R6 comparator gated", lows, 0);

        // Watchdog inside a supply reset: no new bit.
        run_case(0, 0, 1, 5, lows, oes, starts);
        exp_cause = 7'd1;
        check(cause == exp_cause, "R9 no bit during reset", cause, exp_cause);
        check(lows == T + 3, "R2 supply length", lows, T + 3);
        check(oes == T, "R3 pin drive length", oes, T);
        check(starts == 1, "R12 single start", starts, 1);

        // Random source, enable and hold mix.
        for (int it = 0; it < 40; it++) begin
            int src, hold;
            bit alt, ok;
            src = int'($urandom % 7);
            alt = 1'($urandom % 2);
            hold = 1 + int'($urandom % 4);
            en_cnv = 1'($urandom % 2);
            en_cmp = 1'($urandom % 2);
            en_mcd = 1'($urandom % 2);
            ok = en_ok(src);
            run_case(src, alt, hold, 0, lows, oes, starts);
            exp_cause = next_cause(exp_cause, src, ok);
            case (src)
                0: check(lows == exp_low(src, hold, ok), "R2 random length", lows, exp_low(src, hold, ok));
                1: check(lows == exp_low(src, hold, ok), "R5 pin length", lows, exp_low(src, hold, ok));
                3, 6: check(lows == exp_low(src, hold, ok), "R4 direct length", lows, exp_low(src, hold, ok));
                5: check(lows == exp_low(src, hold, ok), "R7 random one-shot", lows, exp_low(src, hold, ok));
                default: begin
                    if (ok) check(lows == exp_low(src, hold, ok), "R5 synced length", lows, exp_low(src, hold, ok));
                    else    check(lows == 0, "R6 gated source", lows, 0);
                end
            endcase
            check(oes == exp_oe(src, hold), "R3 pin drive", oes, exp_oe(src, hold));
            check(cause == exp_cause, "R8 random cause", cause, exp_cause);
            check(starts == (ok ? 1 : 0), "R12 start count", starts, ok ? 1 : 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule